// File: doc/BRIEF.md
# Dendrite Adder Tree Accumulator

This block folds sixty-four signed per-lane synapse results into one partial sum every cycle through a fully registered binary adder tree. The partial sums are accumulated over a programmable number of consecutive blocks, and that number is also the number of blocks that make up one neuron. A block whose slot index is an exact multiple of that count starts a fresh accumulation. That same block also announces a neuron: after a fixed latency the block raises a one-cycle ready strobe and presents the completed sum for the neuron that began at that slot. Alongside the strobe it shows a running neuron number.

The block sits between the synapse lanes and the soma stage, and it carries no activation logic. The blocks of one neuron must be presented on consecutive cycles with the valid flag high. Idle cycles are allowed only between neurons. A bpn-dependent tap on a history of accumulator values picks the finished sum, so the strobe always leaves at the same distance from the neuron's first block.

Top module: `dendrite_accum`

## Requirements
- R1: After reset, `net_sum` is 0, `nrn_rdy` is 0 and `nrn_idx` is 0.
- R2: The sum of one block is the signed sum of the 64 lanes, where lane k occupies bits [16k+15:16k] as a two's-complement value. With `bpn` = 1 each neuron's net sum equals that single block sum.
- R3: For a neuron whose first slot s is a multiple of `bpn`, the net sum equals the sum of the block sums of slots s to s+bpn-1. Nothing from an earlier neuron is carried in.
- R4: For every valid slot that is a multiple of `bpn`, `nrn_rdy` is high for exactly one cycle, 39 cycles after that slot was presented. In that same cycle `net_sum` shows the neuron's sum.
- R5: `nrn_idx` rises by one in the strobe cycle when the announcing slot index is at least `bpn`. A strobe from a lower slot leaves it unchanged, and it does not change without a strobe or a start pulse.
- R6: A `start` pulse sets `nrn_idx` to 0 from the next cycle. When it coincides with an incrementing strobe, the clear wins.
- R7: `net_sum` holds its value in every cycle without a strobe.
- R8: Valid slots whose index is not a multiple of `bpn` produce no strobe.
- R9: Cycles with `slot_vld` low between neurons leave later sums unaffected, whatever the lane data.
- R10: Full-scale lane values over 32 blocks (all -32768, or all 32767) give exact 27-bit results with no wrap.
- R11: `bpn` lies in 1..32 whenever `slot_vld` is high. Both extremes produce correct sums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the neuron index |
| slot_vld | input | 1 | Slot index and lanes are valid |
| slot_idx | input | 12 | Block slot index |
| bpn | input | 6 | Blocks per neuron, 1..32 |
| lanes | input | 1024 | 64 signed 16-bit lane values, lane k at [16k+15:16k] |
| net_sum | output | 27 | Signed net sum of the last announced neuron |
| nrn_rdy | output | 1 | One-cycle neuron-ready strobe |
| nrn_idx | output | 12 | Running neuron number |

## Verification
The neuron index has two writers that can act in one edge: the start clear and the increment from a ready strobe whose slot is past the first neuron. The bench streams blocks with `bpn` = 2 and times a start pulse to land on the edge that raises the second strobe. It expects that strobe to report index 0, because the clear wins, and the following strobe to report 1. The sum delivered with the colliding strobe is checked as well, so an index clear that disturbs the data path would also show.

// File: rtl/dnd_pkg.sv
package dnd_pkg;

  // side-band that travels with each block through the tree
  typedef struct packed {
    logic vld;   // block present
    logic head;  // slot is a multiple of bpn
    logic adv;   // slot at or past bpn: counts toward the neuron index
  } dnd_tag_t;

  // remainder of num / den by restoring subtraction; den of zero returns num
  function automatic logic [15:0] slot_mod(input logic [15:0] num,
                                           input logic [15:0] den);
    logic [16:0] rem;
    rem = '0;
    if (den == 16'd0) return num;
    for (int i = 15; i >= 0; i--) begin
      rem = {rem[15:0], num[i]};
      if (rem >= {1'b0, den}) rem = rem - {1'b0, den};
    end
    return rem[15:0];
  endfunction

  function automatic logic blk_head(input logic [15:0] slot,
                                    input logic [15:0] per);
    return slot_mod(slot, per) == 16'd0;
  endfunction

  function automatic logic blk_adv(input logic [15:0] slot,
                                   input logic [15:0] per);
    return slot >= per;
  endfunction

endpackage

// File: rtl/dnd_tree_level.sv
module dnd_tree_level #(
  parameter int N_IN = 64,
  parameter int IN_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_IN*IN_W-1:0]            din,
  output logic [(N_IN/2)*(IN_W+1)-1:0]    dout
);
  localparam int N_OUT = N_IN / 2;
  localparam int OUT_W = IN_W + 1;

  function automatic logic signed [OUT_W-1:0] pair_add(
    input logic signed [IN_W-1:0] a,
    input logic signed [IN_W-1:0] b);
    return OUT_W'(a) + OUT_W'(b);
  endfunction

  for (genvar i = 0; i < N_OUT; i++) begin : g_pair
    logic signed [IN_W-1:0]  lo_in;
    logic signed [IN_W-1:0]  hi_in;
    logic signed [OUT_W-1:0] sum_q;

    assign lo_in = din[(2*i)*IN_W +: IN_W];
    assign hi_in = din[(2*i+1)*IN_W +: IN_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= '0;
      else        sum_q <= pair_add(lo_in, hi_in);
    end

    assign dout[i*OUT_W +: OUT_W] = sum_q;
  end

endmodule

// File: rtl/dnd_adder_tree.sv
module dnd_adder_tree
  import dnd_pkg::*;
#(
  parameter int NUM_LANES = 64,
  parameter int LANE_W    = 16,
  localparam int LVLS     = $clog2(NUM_LANES),
  localparam int ROOT_W   = LANE_W + LVLS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_LANES*LANE_W-1:0]   lanes,
  input  dnd_tag_t                      tag_in,
  output logic signed [ROOT_W-1:0]      root,
  output dnd_tag_t                      tag_out
);

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int N_L = NUM_LANES >> l;
    localparam int W_L = LANE_W + l;
    logic [N_L*W_L-1:0] bus;

    if (l == 0) begin : g_src
      assign bus = lanes;
    end else begin : g_add
      dnd_tree_level #(
        .N_IN (N_L * 2),
        .IN_W (W_L - 1)
      ) u_level (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (g_lvl[l-1].bus),
        .dout (bus)
      );
    end
  end

  assign root = g_lvl[LVLS].bus;

  // side-band follows the data, one register per level
  dnd_tag_t tag_sr [LVLS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LVLS; k++) tag_sr[k] <= '0;
    end else begin
      tag_sr[0] <= tag_in;
      for (int k = 1; k < LVLS; k++) tag_sr[k] <= tag_sr[k-1];
    end
  end

  assign tag_out = tag_sr[LVLS-1];

endmodule

// File: rtl/dnd_accum.sv
module dnd_accum #(
  parameter int ROOT_W = 22,
  parameter int ACC_W  = 27
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [ROOT_W-1:0] root,
  input  logic                     blk_vld,
  input  logic                     blk_head,
  output logic signed [ACC_W-1:0]  acc_q
);

  function automatic logic signed [ACC_W-1:0] acc_next(
    input logic                     restart,
    input logic signed [ACC_W-1:0]  prev,
    input logic signed [ROOT_W-1:0] part);
    logic signed [ACC_W-1:0] base;
    base = restart ? '0 : prev;
    return base + ACC_W'(part);
  endfunction

  logic acc_restart;
  logic acc_add;
  assign acc_restart = blk_vld &  blk_head;
  assign acc_add     = blk_vld & ~blk_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (blk_vld) acc_q <= acc_next(acc_restart, acc_q, root);
  end

  // R9: an empty slot leaves the running sum alone
  assert_acc_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_restart || acc_add) |=> $stable(acc_q));

endmodule

// File: rtl/dnd_align.sv
module dnd_align
  import dnd_pkg::*;
#(
  parameter int ACC_W = 27,
  parameter int DEPTH = 32,
  parameter int BPN_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ACC_W-1:0] acc_q,
  input  dnd_tag_t                tag_in,
  input  logic [BPN_W-1:0]        bpn,
  output logic signed [ACC_W-1:0] tap_sum,
  output dnd_tag_t                tag_out
);

  // history of accumulator values; position j is j cycles old
  logic signed [ACC_W-1:0] hist_r [1:DEPTH-1];
  // strobe delay line
  dnd_tag_t                sdl    [DEPTH];

  function automatic int tap_pos(input logic [BPN_W-1:0] per);
    return DEPTH - int'(per);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 1; j < DEPTH; j++) hist_r[j] <= '0;
      for (int k = 0; k < DEPTH; k++) sdl[k]    <= '0;
    end else begin
      hist_r[1] <= acc_q;
      for (int j = 2; j < DEPTH; j++) hist_r[j] <= hist_r[j-1];
      sdl[0] <= tag_in;
      for (int k = 1; k < DEPTH; k++) sdl[k] <= sdl[k-1];
    end
  end

  int tap_sel;
  assign tap_sel = tap_pos(bpn);

  always_comb begin
    tap_sum = acc_q;
    for (int j = 1; j < DEPTH; j++)
      if (tap_sel == j) tap_sum = hist_r[j];
  end

  assign tag_out = sdl[DEPTH-1];

endmodule

// File: rtl/dnd_nrn_out.sv
module dnd_nrn_out
  import dnd_pkg::*;
#(
  parameter int ACC_W = 27,
  parameter int NRN_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [ACC_W-1:0] tap_sum,
  input  dnd_tag_t                tag_in,
  output logic [ACC_W-1:0]        net_sum,
  output logic                    nrn_rdy,
  output logic [NRN_W-1:0]        nrn_idx
);

  logic nrn_fire;
  logic idx_step;
  assign nrn_fire = tag_in.vld & tag_in.head;
  assign idx_step = nrn_fire & tag_in.adv;

  function automatic logic [NRN_W-1:0] idx_next(
    input logic             clr,
    input logic             step,
    input logic [NRN_W-1:0] cur);
    if (clr)  return '0;
    if (step) return cur + 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      net_sum <= '0;
      nrn_rdy <= 1'b0;
      nrn_idx <= '0;
    end else begin
      nrn_rdy <= nrn_fire;
      if (nrn_fire) net_sum <= tap_sum;
      nrn_idx <= idx_next(start, idx_step, nrn_idx);
    end
  end

  // R7: the latched sum moves only together with a strobe
  assert_net_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !nrn_rdy |-> $stable(net_sum));

  // R5: the index moves only on a strobe or after a start pulse
  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!nrn_rdy && !$past(start)) |-> $stable(nrn_idx));

  // R6: start always leaves a zero index behind
  assert_start_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (nrn_idx == '0));

endmodule

// File: rtl/dendrite_accum.sv
module dendrite_accum
  import dnd_pkg::*;
#(
  parameter int NUM_LANES = 64,
  parameter int LANE_W    = 16,
  parameter int BPN_MAX   = 32,
  parameter int SLOT_W    = 12,
  parameter int NRN_W     = 12,
  localparam int LVLS     = $clog2(NUM_LANES),
  localparam int ROOT_W   = LANE_W + LVLS,
  localparam int BPN_W    = $clog2(BPN_MAX + 1),
  localparam int ACC_W    = ROOT_W + $clog2(BPN_MAX)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        slot_vld,
  input  logic [SLOT_W-1:0]           slot_idx,
  input  logic [BPN_W-1:0]            bpn,
  input  logic [NUM_LANES*LANE_W-1:0] lanes,
  output logic [ACC_W-1:0]            net_sum,
  output logic                        nrn_rdy,
  output logic [NRN_W-1:0]            nrn_idx
);

  dnd_tag_t                 tag_in;
  dnd_tag_t                 tree_tag;
  dnd_tag_t                 out_tag;
  logic signed [ROOT_W-1:0] root;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  tap_sum;

  assign tag_in.vld  = slot_vld;
  assign tag_in.head = blk_head(16'(slot_idx), 16'(bpn));
  assign tag_in.adv  = blk_adv(16'(slot_idx), 16'(bpn));

  dnd_adder_tree #(
    .NUM_LANES(NUM_LANES),
    .LANE_W   (LANE_W)
  ) u_tree (
    .clk    (clk),
    .rst_n  (rst_n),
    .lanes  (lanes),
    .tag_in (tag_in),
    .root   (root),
    .tag_out(tree_tag)
  );

  dnd_accum #(
    .ROOT_W(ROOT_W),
    .ACC_W (ACC_W)
  ) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .root    (root),
    .blk_vld (tree_tag.vld),
    .blk_head(tree_tag.head),
    .acc_q   (acc_q)
  );

  dnd_align #(
    .ACC_W(ACC_W),
    .DEPTH(BPN_MAX),
    .BPN_W(BPN_W)
  ) u_align (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_q  (acc_q),
    .tag_in (tree_tag),
    .bpn    (bpn),
    .tap_sum(tap_sum),
    .tag_out(out_tag)
  );

  dnd_nrn_out #(
    .ACC_W(ACC_W),
    .NRN_W(NRN_W)
  ) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .tap_sum(tap_sum),
    .tag_in (out_tag),
    .net_sum(net_sum),
    .nrn_rdy(nrn_rdy),
    .nrn_idx(nrn_idx)
  );

  // R11: the block count per neuron stays inside the supported range
  assert_bpn_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld |-> (bpn >= BPN_W'(1) && bpn <= BPN_W'(BPN_MAX)));

  // R2: a block leaves the tree exactly one cycle per level after entry
  assert_tree_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tree_tag.vld |-> $past(slot_vld, LVLS));

  // R8: a strobe always traces back to a head block
  assert_strobe_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nrn_rdy |-> $past(out_tag.head));

endmodule

// File: tb/dendrite_accum_tb.sv
`timescale 1ns/1ps
module dendrite_accum_tb;

  localparam int NL  = 64;
  localparam int LW  = 16;
  localparam int AW  = 27;
  localparam int LAT = 39;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            slot_vld = 1'b0;
  logic [11:0]     slot_idx = '0;
  logic [5:0]      bpn = 6'd1;
  logic [NL*LW-1:0] lanes = '0;
  logic [AW-1:0]   net_sum;
  logic            nrn_rdy;
  logic [11:0]     nrn_idx;

  always #2.5 clk = ~clk;

  dendrite_accum u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .slot_vld(slot_vld),
    .slot_idx(slot_idx), .bpn(bpn), .lanes(lanes),
    .net_sum(net_sum), .nrn_rdy(nrn_rdy), .nrn_idx(nrn_idx));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // observed strobes
  int     ev_n = 0;
  int     ev_cyc [64];
  longint ev_sum [64];
  int     ev_idx [64];
  longint last_net = 0;
  int     hold_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (nrn_rdy) begin
        if (ev_n < 64) begin
          ev_cyc[ev_n] = cyc;
          ev_sum[ev_n] = longint'($signed(net_sum));
          ev_idx[ev_n] = int'(nrn_idx);
        end
        ev_n++;
        last_net = longint'($signed(net_sum));
      end else if (longint'($signed(net_sum)) != last_net) begin
        hold_bad++;
      end
    end
  end

  // expected strobes
  int     ex_n;
  int     ex_cyc [64];
  longint ex_sum [64];
  int     ex_idx [64];
  int     idx_m;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lane_val(input int seed, input int lane);
    if (seed == -1) return -32768;
    if (seed == -2) return 32767;
    return ((seed * 7919 + lane * 104729) % 4001) - 2000;
  endfunction

  function automatic longint blk_sum(input int seed);
    longint s = 0;
    for (int k = 0; k < NL; k++) s += lane_val(seed, k);
    return s;
  endfunction

  task automatic load_lanes(input int seed);
    for (int k = 0; k < NL; k++) lanes[k*LW +: LW] = 16'(lane_val(seed, k));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      slot_vld = 1'b0;
      load_lanes(999 + i);
      @(negedge clk);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx_m = 0;
  endtask

  task automatic begin_task(input int per);
    ex_n = 0;
    ev_n = 0;
    bpn = 6'(per);
    pulse_start();
  endtask

  // contiguous blocks first..first+cnt-1, seed = base + slot
  task automatic stream(input int base, input int first, input int cnt, input int per);
    for (int s = first; s < first + cnt; s++) begin
      if (s % per == 0) begin
        longint tot = 0;
        for (int b = 0; b < per; b++) tot += blk_sum(base + s + b);
        if (s >= per) idx_m++;
        ex_cyc[ex_n] = cyc + LAT;
        ex_sum[ex_n] = tot;
        ex_idx[ex_n] = idx_m;
        ex_n++;
      end
      slot_vld = 1'b1;
      slot_idx = 12'(s);
      load_lanes(base + s);
      @(negedge clk);
    end
    slot_vld = 1'b0;
  endtask

  task automatic verify(input string r_cnt, input string r_time,
                        input string r_sum, input string r_idx);
    check(r_cnt, "strobe count", ev_n, ex_n);
    for (int i = 0; i < ex_n && i < ev_n; i++) begin
      check(r_time, $sformatf("strobe %0d cycle", i), ev_cyc[i], ex_cyc[i]);
      check(r_sum,  $sformatf("strobe %0d sum", i),   ev_sum[i], ex_sum[i]);
      check(r_idx,  $sformatf("strobe %0d index", i), ev_idx[i], ex_idx[i]);
    end
  endtask

  task automatic t_reset();
    check("R1", "net_sum after reset", longint'(net_sum), 0);
    check("R1", "nrn_rdy after reset", longint'(nrn_rdy), 0);
    check("R1", "nrn_idx after reset", longint'(nrn_idx), 0);
  endtask

  task automatic t_single();   // R2 R4 R5 R11 with bpn=1
    begin_task(1);
    stream(10, 0, 4, 1);
    idle(LAT + 8);
    verify("R11", "R4", "R2", "R5");
  endtask

  task automatic t_multi();    // R3 R8 R7 with bpn=4
    begin_task(4);
    stream(40, 0, 12, 4);
    idle(LAT + 8);
    verify("R8", "R4", "R3", "R5");
    check("R7", "net_sum held after last strobe",
          longint'($signed(net_sum)), ex_sum[ex_n-1]);
  endtask

  task automatic t_gap();      // R9 idle cycles with junk lanes between neurons
    begin_task(3);
    stream(70, 0, 6, 3);
    idle(5);
    stream(70, 6, 3, 3);
    idle(LAT + 8);
    verify("R8", "R4", "R9", "R5");
  endtask

  task automatic t_full();     // R10 R11 with bpn=32
    begin_task(32);
    ex_n = 2;
    for (int s = 0; s < 64; s++) begin
      if (s == 0)  ex_cyc[0] = cyc + LAT;
      if (s == 32) ex_cyc[1] = cyc + LAT;
      slot_vld = 1'b1;
      slot_idx = 12'(s);
      load_lanes(s < 32 ? -1 : -2);
      @(negedge clk);
    end
    slot_vld = 1'b0;
    ex_sum[0] = -64'sd67108864;  ex_idx[0] = 0;
    ex_sum[1] = 64'sd67106816;   ex_idx[1] = 1;
    idle(LAT + 8);
    verify("R11", "R4", "R10", "R5");
  endtask

  task automatic t_offset();   // R5 first strobe past slot zero counts
    begin_task(4);
    stream(120, 8, 8, 4);
    idle(LAT + 8);
    verify("R8", "R4", "R3", "R5");
  endtask

  task automatic t_collide();  // R6 start on the edge of an incrementing strobe
    int c0;
    begin_task(2);
    c0 = cyc;
    stream(150, 0, 6, 2);
    while (cyc != c0 + LAT + 1) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ex_idx[1] = 0;
    ex_idx[2] = 1;
    idle(LAT + 8);
    verify("R8", "R4", "R3", "R6");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    load_lanes(0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_gap();
    t_full();
    t_offset();
    t_collide();
    check("R7", "net_sum changes without strobe", hold_bad, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule